// File: doc/BRIEF.md
# Integer ALU with Overflow Trapping

This block is the combinational integer arithmetic and logic stage of a small load/store processor datapath. It accepts two source operands and a 4-bit operation code and produces a data-width result plus one overflow-exception flag in the same cycle. The second operand arrives already selected and already expanded: the register-versus-immediate choice is made upstream. Writing the result back, and acting on the flag, belong to surrounding logic.

Addition and subtraction come in a signed form and an unsigned form. Both forms produce identical result bits. Only the signed form may raise the exception flag, and it does so when the two's-complement result does not fit in the data width. The bitwise group offers AND, OR, XOR, NOR and a one-operand NOT. None of them ever raises the flag. Codes outside the defined set give a zero result with the flag clear.

Top module: `arith_logic_unit`

## Requirements
- R1: Code 0 (signed add) and code 1 (unsigned add) both return (a + b) modulo 2^DATA_W.
- R2: Code 2 (signed subtract) and code 3 (unsigned subtract) both return (a - b) modulo 2^DATA_W.
- R3: With code 0, the flag is 1 exactly when a and b have equal sign bits and the result's sign bit differs from them.
- R4: With code 2, the flag is 1 exactly when a and b have different sign bits and the result's sign bit differs from that of a.
- R5: With code 1 or code 3 the flag is always 0, even for operands that overflow the signed range.
- R6: Codes 4, 5, 6 and 7 return a AND b, a OR b, a XOR b and NOT(a OR b), and the flag is 0.
- R7: Code 8 returns the bitwise inverse of a, and b has no effect on the result. The flag is 0.
- R8: Codes 9 through 15 return zero with the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | DATA_W | First operand |
| src_b_i | input | DATA_W | Second operand: a register value or an expanded immediate |
| op_i | input | 4 | Operation code (0..8 defined) |
| result_o | output | DATA_W | Operation result |
| ovf_trap_o | output | 1 | Signed add/subtract overflow exception |

## Verification
The hardest condition to reach from the ports is a signed overflow that sits exactly on the range edges. Examples are 0x7FFFFFFF + 1, 0x80000000 - 1 and 0x80000000 + 0x80000000, together with the matching unsigned codes, which must give the same bits with the flag silent. Uniform random operands seldom land on these edges. The stimulus therefore sweeps every pair drawn from {0, 1, 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF} through all sixteen codes before the random phase. That sweep also varies b under code 8, which shows that NOT ignores its second operand.

// File: rtl/alu_pkg.sv
package alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'd0,
      OP_ADDU = 4'd1,
      OP_SUB  = 4'd2,
      OP_SUBU = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_NOR  = 4'd7,
      OP_NOT  = 4'd8
   } alu_op_e;

   localparam logic [OP_W-1:0] OP_LAST = OP_NOT;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W         = 32,
   parameter bit OVF_FROM_CARRY = 1'b0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              ovf_o
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W-1:0] cin_vec;

   assign b_eff   = sub_i ? ~b_i : b_i;
   assign cin_vec = {{(DATA_W-1){1'b0}}, sub_i};

   generate
      if (OVF_FROM_CARRY) begin : g_carry
         logic [DATA_W:0] wide;
         logic [MSB:0]    low;
         assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {1'b0, cin_vec};
         assign low   = {1'b0, a_i[MSB-1:0]} + {1'b0, b_eff[MSB-1:0]}
                      + {1'b0, cin_vec[MSB-1:0]};
         assign sum_o = wide[DATA_W-1:0];
         assign ovf_o = low[MSB] ^ wide[DATA_W];
      end else begin : g_sign
         assign sum_o = a_i + b_eff + cin_vec;
         assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
      end
   endgenerate

   always_comb begin
      if (!sub_i && ovf_o) begin
         p_add_ovf_signs_r3: assert (a_i[MSB] == b_i[MSB])
            else $error("add overflow with unlike operand signs");
      end
      if (sub_i && ovf_o) begin
         p_sub_ovf_signs_r4: assert (a_i[MSB] != b_i[MSB])
            else $error("subtract overflow with like operand signs");
      end
   end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [1:0]        fn_i,
   input  logic              invert_i,
   output logic [DATA_W-1:0] y_o
);

   logic [DATA_W-1:0] two_op;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         always_comb begin
            unique case (fn_i)
               2'd0:    two_op[i] = a_i[i] & b_i[i];
               2'd1:    two_op[i] = a_i[i] | b_i[i];
               2'd2:    two_op[i] = a_i[i] ^ b_i[i];
               default: two_op[i] = ~(a_i[i] | b_i[i]);
            endcase
         end
      end
   endgenerate

   assign y_o = invert_i ? ~a_i : two_op;

   always_comb begin
      if (invert_i) begin
         p_not_inverts_r7: assert ((y_o ^ a_i) == {DATA_W{1'b1}})
            else $error("inverse result does not complement operand a");
      end
   end

endmodule

// File: rtl/arith_logic_unit.sv
module arith_logic_unit
   import alu_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter bit OVF_FROM_CARRY = 1'b0
) (
   input  logic [DATA_W-1:0] src_a_i,
   input  logic [DATA_W-1:0] src_b_i,
   input  logic [OP_W-1:0]   op_i,
   output logic [DATA_W-1:0] result_o,
   output logic              ovf_trap_o
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic              is_arith;
   logic              is_logic;
   logic              is_invert;
   logic              trap_en;
   logic [DATA_W-1:0] arith_y;
   logic              arith_ovf;
   logic [DATA_W-1:0] logic_y;

   assign is_arith  = (op_i[OP_W-1:2] == '0);
   assign is_invert = (op_i == OP_NOT);
   assign is_logic  = (op_i[OP_W-1:2] == 2'b01) || is_invert;
   assign trap_en   = is_arith && !op_i[0];

   alu_addsub #(
      .DATA_W        (DATA_W),
      .OVF_FROM_CARRY(OVF_FROM_CARRY)
   ) u_addsub (
      .a_i  (src_a_i),
      .b_i  (src_b_i),
      .sub_i(op_i[1]),
      .sum_o(arith_y),
      .ovf_o(arith_ovf)
   );

   alu_bitwise #(
      .DATA_W(DATA_W)
   ) u_bitwise (
      .a_i     (src_a_i),
      .b_i     (src_b_i),
      .fn_i    (op_i[1:0]),
      .invert_i(is_invert),
      .y_o     (logic_y)
   );

   always_comb begin
      result_o = '0;
      if (is_arith)      result_o = arith_y;
      else if (is_logic) result_o = logic_y;
   end

   assign ovf_trap_o = trap_en && arith_ovf;

   always_comb begin
      if (ovf_trap_o) begin
         p_flag_signed_only_r5: assert (op_i == OP_ADD || op_i == OP_SUB)
            else $error("overflow flag raised by a non-trapping code");
      end
      if (op_i > OP_LAST) begin
         p_unused_zero_r8: assert (result_o == '0 && !ovf_trap_o)
            else $error("unused code produced nonzero output");
      end
      if (is_logic) begin
         p_logic_no_flag_r6: assert (!ovf_trap_o)
            else $error("bitwise code raised overflow");
      end
   end

endmodule

// File: tb/arith_logic_unit_bench.sv
module arith_logic_unit_bench;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a, b;
   logic [3:0]   op;
   logic [W-1:0] res;
   logic         ovf;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   arith_logic_unit #(.DATA_W(W)) u_arith_logic_unit (
      .src_a_i   (a),
      .src_b_i   (b),
      .op_i      (op),
      .result_o  (res),
      .ovf_trap_o(ovf)
   );

   function automatic string req_of(input logic [3:0] c);
      case (c)
         4'd0:       return "R1 R3";
         4'd1:       return "R1 R5";
         4'd2:       return "R2 R4";
         4'd3:       return "R2 R5";
         4'd4, 4'd5,
         4'd6, 4'd7: return "R6";
         4'd8:       return "R7";
         default:    return "R8";
      endcase
   endfunction

   task automatic model(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic [3:0] c,
                        output logic [W-1:0] er, output logic ef);
      longint sx, sy, s;
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      ef = 1'b0;
      er = '0;
      case (c)
         4'd0, 4'd1: begin
            s  = sx + sy;
            er = x + y;
            ef = (c == 4'd0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
         end
         4'd2, 4'd3: begin
            s  = sx - sy;
            er = x - y;
            ef = (c == 4'd2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
         end
         4'd4: er = x & y;
         4'd5: er = x | y;
         4'd6: er = x ^ y;
         4'd7: er = ~(x | y);
         4'd8: er = ~x;
         default: er = '0;
      endcase
   endtask

   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic [3:0] c);
      logic [W-1:0] er;
      logic         ef;
      @(posedge clk);
      a  = x;
      b  = y;
      op = c;
      @(negedge clk);
      model(x, y, c, er, ef);
      n_cmp++;
      if (res !== er || ovf !== ef) begin
         n_bad++;
         $display("FAIL %s op=%0d a=%h b=%h: got res=%h ovf=%b, expected res=%h ovf=%b",
                  req_of(c), c, x, y, res, ovf, er, ef);
      end
   endtask

   logic [W-1:0] edges [5];

   initial begin
      edges[0] = 32'h0000_0000;
      edges[1] = 32'h0000_0001;
      edges[2] = 32'h7FFF_FFFF;
      edges[3] = 32'h8000_0000;
      edges[4] = 32'hFFFF_FFFF;
      a = '0; b = '0; op = 4'd0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: zero operands under add give zero, flag low (R1)
      apply('0, '0, 4'd0);
      // directed edge cases named by R3, R4, R5
      apply(32'h7FFF_FFFF, 32'h1, 4'd0);   // R3 overflow
      apply(32'h7FFF_FFFF, 32'h1, 4'd1);   // R5 same bits, no flag
      apply(32'h8000_0000, 32'h1, 4'd2);   // R4 overflow
      apply(32'h8000_0000, 32'h1, 4'd3);   // R5
      apply(32'h8000_0000, 32'h8000_0000, 4'd0); // R3 negative overflow
      apply(32'h1234_5678, 32'hFFFF_0000, 4'd8); // R7 b ignored
      apply(32'h1234_5678, 32'h0000_0000, 4'd8); // R7
      apply(32'hDEAD_BEEF, 32'hFFFF_FFFF, 4'd15); // R8
      // full sweep of edge pairs over every code
      for (int i = 0; i < 5; i++)
         for (int j = 0; j < 5; j++)
            for (int c = 0; c < 16; c++)
               apply(edges[i], edges[j], 4'(c));
      // random phase
      for (int k = 0; k < 3000; k++)
         apply($urandom, $urandom, 4'($urandom_range(0, 15)));
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule